// File: doc/BRIEF.md
# System Reset Source Hub

This block collects every reset request of a small microcontroller-style system and turns them into one system reset output. It also controls a shared open-drain reset pad: the pad level comes back in as `pinIn`, the block pulls it low through `pinDriveLow`, and it switches the pad's pull-up through `pullUpEn`. A low level that arrives from outside on the pad must survive a digital glitch filter before it counts. A request from any on-chip source (two watchdogs, two processor software requests, brown-out, option-loader launch, a radio protocol error when that source is built in, and the low-power manager) starts a pad pulse of guaranteed minimum length. The pull-up is switched off for as long as that pulse drives the pad.

The low-power manager reports a finished entry into Stop, Standby or Shutdown with a one-cycle strobe and a mode code. Three active-low option bits decide, per mode, whether that entry becomes a reset or is passed on as a grant. A sticky flag register records which sources caused resets. Software clears it by writing ones. A brown-out or power-on event leaves only the brown-out flag set.

Top module: `reset_hub`

## Requirements
- R1: `sysRst` is high while `porRstN` is low. It is also high from the first clock edge at which any on-chip request input is sampled high, and it stays high for as long as that request stays high, while the pad pulse runs, and while the filtered external low is accepted. It is low otherwise.
- R2: A newly asserted on-chip request drives `pinDriveLow` high from the same clock edge that samples it. The drive lasts exactly PULSE_CYC = ceil(CLK_HZ × 20 / 1,000,000) cycles, which is 20 µs.
- R3: A new on-chip request that rises while a pulse is running restarts the pulse length from that edge. With a second request k cycles after the first (k < PULSE_CYC), the total drive is k + PULSE_CYC cycles.
- R4: `pullUpEn` is low exactly while `pinDriveLow` is high, and is high otherwise.
- R5: An external low on `pinIn` is accepted only after it has been sampled low for FILT_LEN consecutive cycles behind a two-stage synchronizer. A low held for d cycles is accepted iff d ≥ FILT_LEN, and `sysRst` rises FILT_LEN+1 edges after the first low edge. An accepted external low never drives the pad. The pad's own drive, plus a two-cycle tail after it, is not taken as external.
- R6: Low-power mode codes are 01 Stop, 10 Standby and 11 Shutdown. The matching option bit is `optLpRstN[0]`, `[1]` or `[2]`. When the strobe `lpEntryDone` comes with a nonzero code and the matching bit is 0, no grant is given. Instead a reset request is raised one edge later, which sets flag bit 5 and starts the pad pulse.
- R7: When the matching option bit is 1, `lpGrant` is high for one cycle after the strobe edge, with `lpGrantMode` equal to the code. Code 00 causes neither a grant nor a reset, and `lpGrantMode` reads 00 when no grant is given.
- R8: `rstFlags` bit positions are 0 external pin, 1 window watchdog, 2 independent watchdog, 3 software CPU0, 4 software CPU1, 5 low-power, 6 option loader, 7 brown-out, 8 radio error. A bit is set at the edge where its source newly asserts, and it stays set until cleared.
- R9: When `flagClrWr` is high, each flag whose `flagClrMask` bit is 1 is cleared at the next edge. Flags whose mask bit is 0 are kept. A source that sets a flag in the same cycle wins over the clear.
- R10: After `porRstN` is released, and at the edge where `borReq` newly asserts, `rstFlags` holds only bit 7, together with any other flags set in that same cycle.
- R11: With HAS_RADIO = 1, `radioErr` behaves like every other on-chip source on flag bit 8. With HAS_RADIO = 0, it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| pinIn | input | 1 | Level read back from the reset pad |
| pinDriveLow | output | 1 | Pull the open-drain pad low |
| pullUpEn | output | 1 | Enable of the pad's internal pull-up |
| wwdgReq | input | 1 | Window watchdog reset request |
| iwdgReq | input | 1 | Independent watchdog reset request |
| swReq | input | 2 | Software reset requests, one per processor |
| borReq | input | 1 | Brown-out detector request |
| oblLaunch | input | 1 | Option-loader launch bit |
| radioErr | input | 1 | Radio protocol error request |
| lpEntryDone | input | 1 | One-cycle strobe: low-power entry sequence finished |
| lpMode | input | 2 | Mode of that entry (01 Stop, 10 Standby, 11 Shutdown) |
| optLpRstN | input | 3 | Active-low option bits: reset instead of Stop/Standby/Shutdown |
| lpGrant | output | 1 | One-cycle grant to enter the low-power mode |
| lpGrantMode | output | 2 | Mode code carried with the grant |
| flagClrWr | input | 1 | Flag clear command |
| flagClrMask | input | 9 | Write-one-to-clear mask for the flags |
| rstFlags | output | 9 | Sticky reset-cause flags |
| sysRst | output | 1 | System reset, active high |

## Verification
On-chip requests register at the edge that samples them. Flags, `sysRst` and the pad drive are therefore due at the sample straight after that edge, while a low-power reset arrives one edge later and its grant arrives right after the strobe edge. An external low is due FILT_LEN+1 edges after the first low sample. The bench drives on falling edges and samples at the next falling edge. It counts pad-low samples one by one against PULSE_CYC, which it computes itself from the clock rate. It indexes each filter and low-power case by its edge count from the stimulus, so every check falls in the cycle its result is due.

// File: rtl/reset_hub_pkg.sv
package reset_hub_pkg;

  localparam int NUM_SRC   = 9;
  localparam int SRC_PIN   = 0;
  localparam int SRC_WWDG  = 1;
  localparam int SRC_IWDG  = 2;
  localparam int SRC_SW0   = 3;
  localparam int SRC_SW1   = 4;
  localparam int SRC_LP    = 5;
  localparam int SRC_OBL   = 6;
  localparam int SRC_BOR   = 7;
  localparam int SRC_RADIO = 8;

  typedef logic [NUM_SRC-1:0] srcVec_t;

  localparam srcVec_t BOR_ONLY = srcVec_t'(1) << SRC_BOR;

  typedef enum logic [1:0] {
    LP_NONE  = 2'b00,
    LP_STOP  = 2'b01,
    LP_STDBY = 2'b10,
    LP_SHDN  = 2'b11
  } lpMode_e;

  // strobes from control to datapath
  typedef struct packed {
    srcVec_t setMask;   // sources newly asserted this cycle
    logic    borWipe;   // brown-out rose: drop all other flags
    logic    pulseLoad; // (re)start the pad pulse
  } hubStrobe_t;

endpackage

// File: rtl/reset_hub_ctrl.sv
module reset_hub_ctrl
  import reset_hub_pkg::*;
#(
  parameter bit HAS_RADIO = 1'b1
) (
  input  logic       clk,
  input  logic       porRstN,
  input  logic       wwdgReq,
  input  logic       iwdgReq,
  input  logic [1:0] swReq,
  input  logic       borReq,
  input  logic       oblLaunch,
  input  logic       radioErr,
  input  logic       lpEntryDone,
  input  logic [1:0] lpMode,
  input  logic [2:0] optLpRstN,
  output hubStrobe_t strobe,
  output logic       intActive,
  output logic       lpGrant,
  output logic [1:0] lpGrantMode
);

  logic    radioGated;
  logic    modeValid;
  logic    optSel;
  logic    lpRstQ;
  srcVec_t intNow;
  srcVec_t reqQ;
  srcVec_t rise;

  generate
    if (HAS_RADIO) begin : g_radio
      assign radioGated = radioErr;
    end else begin : g_noRadio
      assign radioGated = 1'b0;
    end
  endgenerate

  // pick the option bit that belongs to the requested mode
  always_comb begin
    case (lpMode)
      LP_STOP:  optSel = optLpRstN[0];
      LP_STDBY: optSel = optLpRstN[1];
      LP_SHDN:  optSel = optLpRstN[2];
      default:  optSel = 1'b1;
    endcase
  end

  assign modeValid = lpEntryDone && (lpMode != LP_NONE);

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      lpRstQ      <= 1'b0;
      lpGrant     <= 1'b0;
      lpGrantMode <= LP_NONE;
    end else begin
      lpRstQ      <= modeValid && !optSel;
      lpGrant     <= modeValid && optSel;
      lpGrantMode <= (modeValid && optSel) ? lpMode : LP_NONE;
    end
  end

  // on-chip request vector in flag order; the pin bit comes from the filter
  always_comb begin
    intNow            = '0;
    intNow[SRC_WWDG]  = wwdgReq;
    intNow[SRC_IWDG]  = iwdgReq;
    intNow[SRC_SW0]   = swReq[0];
    intNow[SRC_SW1]   = swReq[1];
    intNow[SRC_LP]    = lpRstQ;
    intNow[SRC_OBL]   = oblLaunch;
    intNow[SRC_BOR]   = borReq;
    intNow[SRC_RADIO] = radioGated;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) reqQ <= '0;
    else          reqQ <= intNow;
  end

  assign rise = intNow & ~reqQ;

  always_comb begin
    strobe.setMask   = rise;
    strobe.borWipe   = rise[SRC_BOR];
    strobe.pulseLoad = |rise;
  end

  assign intActive = |reqQ;

endmodule

// File: rtl/reset_hub_dp.sv
module reset_hub_dp
  import reset_hub_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 64'd48_000_000,
  parameter int              FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       porRstN,
  input  logic       pinIn,
  input  hubStrobe_t strobe,
  input  logic       flagClrWr,
  input  srcVec_t    flagClrMask,
  output logic       pinDriveLow,
  output logic       pullUpEn,
  output logic       extLow,
  output srcVec_t    rstFlags
);

  localparam longint unsigned PULSE_L = (CLK_HZ * 64'd20 + 64'd999_999) / 64'd1_000_000;
  localparam int PULSE_CYC = (PULSE_L == 0) ? 1 : int'(PULSE_L);
  localparam int CNT_W     = $clog2(PULSE_CYC + 1);
  localparam int FILT_W    = $clog2(FILT_LEN + 1);

  logic              syncA;
  logic              syncB;
  logic [1:0]        driveHist;
  logic              holdFilt;
  logic [FILT_W-1:0] filtCnt;
  logic              extHit;
  logic [CNT_W-1:0]  pulseCnt;
  logic [CNT_W-1:0]  pulseNext;
  srcVec_t           setAll;
  srcVec_t           clrVec;

  // pad synchronizer
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  // own drive and the synchronizer tail behind it are not external lows
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) driveHist <= '0;
    else          driveHist <= {driveHist[0], pinDriveLow};
  end

  assign holdFilt = pinDriveLow || (|driveHist);
  assign extHit   = !holdFilt && !syncB && (filtCnt == FILT_W'(FILT_LEN - 1));

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      filtCnt <= '0;
    end else if (holdFilt || syncB) begin
      filtCnt <= '0;
    end else if (filtCnt != FILT_W'(FILT_LEN)) begin
      filtCnt <= filtCnt + 1'b1;
    end
  end

  assign extLow = (filtCnt == FILT_W'(FILT_LEN));

  // pad pulse stretcher
  always_comb begin
    if (strobe.pulseLoad)   pulseNext = CNT_W'(PULSE_CYC);
    else if (pulseCnt != 0) pulseNext = pulseCnt - 1'b1;
    else                    pulseNext = '0;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      pulseCnt    <= '0;
      pinDriveLow <= 1'b0;
      pullUpEn    <= 1'b1;
    end else begin
      pulseCnt    <= pulseNext;
      pinDriveLow <= (pulseNext != 0);
      pullUpEn    <= (pulseNext == 0);
    end
  end

  // sticky cause flags, set beats clear
  always_comb begin
    setAll          = strobe.setMask;
    setAll[SRC_PIN] = extHit;
    clrVec          = flagClrWr ? flagClrMask : '0;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)           rstFlags <= BOR_ONLY;
    else if (strobe.borWipe) rstFlags <= setAll;
    else                    rstFlags <= (rstFlags & ~clrVec) | setAll;
  end

endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import reset_hub_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 64'd48_000_000,
  parameter int              FILT_LEN  = 4,
  parameter bit              HAS_RADIO = 1'b1
) (
  input  logic       clk,
  input  logic       porRstN,
  input  logic       pinIn,
  output logic       pinDriveLow,
  output logic       pullUpEn,
  input  logic       wwdgReq,
  input  logic       iwdgReq,
  input  logic [1:0] swReq,
  input  logic       borReq,
  input  logic       oblLaunch,
  input  logic       radioErr,
  input  logic       lpEntryDone,
  input  logic [1:0] lpMode,
  input  logic [2:0] optLpRstN,
  output logic       lpGrant,
  output logic [1:0] lpGrantMode,
  input  logic       flagClrWr,
  input  logic [8:0] flagClrMask,
  output logic [8:0] rstFlags,
  output logic       sysRst
);

  hubStrobe_t strobe;
  logic       intActive;
  logic       extLow;

  reset_hub_ctrl #(
    .HAS_RADIO(HAS_RADIO)
  ) u_ctrl (
    .clk        (clk),
    .porRstN    (porRstN),
    .wwdgReq    (wwdgReq),
    .iwdgReq    (iwdgReq),
    .swReq      (swReq),
    .borReq     (borReq),
    .oblLaunch  (oblLaunch),
    .radioErr   (radioErr),
    .lpEntryDone(lpEntryDone),
    .lpMode     (lpMode),
    .optLpRstN  (optLpRstN),
    .strobe     (strobe),
    .intActive  (intActive),
    .lpGrant    (lpGrant),
    .lpGrantMode(lpGrantMode)
  );

  reset_hub_dp #(
    .CLK_HZ  (CLK_HZ),
    .FILT_LEN(FILT_LEN)
  ) u_dp (
    .clk        (clk),
    .porRstN    (porRstN),
    .pinIn      (pinIn),
    .strobe     (strobe),
    .flagClrWr  (flagClrWr),
    .flagClrMask(flagClrMask),
    .pinDriveLow(pinDriveLow),
    .pullUpEn   (pullUpEn),
    .extLow     (extLow),
    .rstFlags   (rstFlags)
  );

  assign sysRst = !porRstN || extLow || intActive || pinDriveLow;

endmodule

// File: rtl/reset_hub_chk.sv
module reset_hub_chk (
  input logic       clk,
  input logic       porRstN,
  input logic       pinDriveLow,
  input logic       pullUpEn,
  input logic [1:0] swReq,
  input logic       borReq,
  input logic       lpEntryDone,
  input logic [1:0] lpMode,
  input logic [2:0] optLpRstN,
  input logic       lpGrant,
  input logic [1:0] lpGrantMode,
  input logic [8:0] rstFlags
);

  AST_PULLUP_OFF: assert property (@(posedge clk) disable iff (!porRstN)
    pinDriveLow |-> !pullUpEn); // R4

  AST_FLAG_ON_DRIVE: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(pinDriveLow) |-> (rstFlags[8:1] != 8'd0)); // R8

  AST_SW_FLAG: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(swReq[0]) |=> rstFlags[3]); // R8

  AST_GRANT_ECHO: assert property (@(posedge clk) disable iff (!porRstN)
    lpGrant |-> ($past(lpEntryDone) && (lpGrantMode == $past(lpMode)))); // R7

  AST_STOP_NO_GRANT: assert property (@(posedge clk) disable iff (!porRstN)
    (lpEntryDone && lpMode == 2'b01 && !optLpRstN[0]) |=> !lpGrant); // R6

  AST_BOR_KEEP: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(borReq) |=> rstFlags[7]); // R10

endmodule

bind reset_hub reset_hub_chk u_chk (
  .clk        (clk),
  .porRstN    (porRstN),
  .pinDriveLow(pinDriveLow),
  .pullUpEn   (pullUpEn),
  .swReq      (swReq),
  .borReq     (borReq),
  .lpEntryDone(lpEntryDone),
  .lpMode     (lpMode),
  .optLpRstN  (optLpRstN),
  .lpGrant    (lpGrant),
  .lpGrantMode(lpGrantMode),
  .rstFlags   (rstFlags)
);

// File: tb/reset_hub_bench.sv
module reset_hub_bench;

  localparam int CLK_PERIOD = 10;
  localparam longint unsigned TB_HZ = 64'd430_000;
  localparam int TB_FILT = 3;
  localparam int EXP_P = int'((TB_HZ * 64'd20 + 64'd999_999) / 64'd1_000_000);

  logic       clk = 1'b0;
  logic       porRstN = 1'b0;
  logic       extPull = 1'b0;
  logic       pinIn;
  logic       pinDriveLow, pullUpEn;
  logic       wwdgReq = 0, iwdgReq = 0, borReq = 0, oblLaunch = 0, radioErr = 0;
  logic [1:0] swReq = 2'b00;
  logic       lpEntryDone = 0;
  logic [1:0] lpMode = 2'b00;
  logic [2:0] optLpRstN = 3'b111;
  logic       lpGrant;
  logic [1:0] lpGrantMode;
  logic       flagClrWr = 0;
  logic [8:0] flagClrMask = '0;
  logic [8:0] rstFlags;
  logic       sysRst;

  int vectors = 0;
  int misses = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // open-drain pad: low if anybody pulls
  assign pinIn = !(extPull || pinDriveLow);

  reset_hub #(
    .CLK_HZ(TB_HZ), .FILT_LEN(TB_FILT), .HAS_RADIO(1'b1)
  ) u_reset_hub (
    .clk(clk), .porRstN(porRstN), .pinIn(pinIn), .pinDriveLow(pinDriveLow),
    .pullUpEn(pullUpEn), .wwdgReq(wwdgReq), .iwdgReq(iwdgReq), .swReq(swReq),
    .borReq(borReq), .oblLaunch(oblLaunch), .radioErr(radioErr),
    .lpEntryDone(lpEntryDone), .lpMode(lpMode), .optLpRstN(optLpRstN),
    .lpGrant(lpGrant), .lpGrantMode(lpGrantMode), .flagClrWr(flagClrWr),
    .flagClrMask(flagClrMask), .rstFlags(rstFlags), .sysRst(sysRst)
  );

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic setSrc(input int idx, input logic v);
    case (idx)
      1: wwdgReq = v;
      2: iwdgReq = v;
      3: swReq[0] = v;
      4: swReq[1] = v;
      6: oblLaunch = v;
      7: borReq = v;
      8: radioErr = v;
      default: ;
    endcase
  endtask

  // ends one sample after the edge that takes the clear
  task automatic clearAll();
    flagClrWr = 1'b1;
    flagClrMask = 9'h1FF;
    @(negedge clk);
    flagClrWr = 1'b0;
    flagClrMask = '0;
  endtask

  // one-cycle request; ends at the sample after the edge that takes it
  task automatic pulseSrc(input int idx);
    setSrc(idx, 1'b1);
    @(negedge clk);
    setSrc(idx, 1'b0);
  endtask

  task automatic countLow(output int lowCnt);
    lowCnt = pinDriveLow ? 1 : 0;
    for (int k = 0; k < 200 && pinDriveLow; k++) begin
      @(negedge clk);
      if (pinDriveLow) lowCnt++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    misses++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int lowCnt;
    int firstHigh;
    logic seenDrive;
    logic seenRst;
    logic expRst;
    logic expGrant;

    repeat (3) @(negedge clk);
    checkEq("R1 sysRst during porRstN", sysRst, 1);
    porRstN = 1'b1;
    @(negedge clk);
    // R10 reset state keeps only the brown-out flag
    checkEq("R10 flags after power-on", rstFlags, 9'h080);
    checkEq("R2 no drive at reset", pinDriveLow, 0);
    checkEq("R4 pull-up on at reset", pullUpEn, 1);
    checkEq("R1 sysRst idle", sysRst, 0);
    checkEq("R7 no grant at reset", lpGrant, 0);

    // R8 sweep over every single on-chip source (R11 covers index 8)
    for (int idx = 1; idx <= 8; idx++) begin
      if (idx == 5) continue;
      clearAll();
      pulseSrc(idx);
      checkEq("R2 drive starts", pinDriveLow, 1);
      checkEq("R4 pull-up off while driving", pullUpEn, 0);
      checkEq("R1 sysRst on request", sysRst, 1);
      checkEq(idx == 8 ? "R11 radio flag" : "R8 flag of source", rstFlags, 9'(1) << idx);
      countLow(lowCnt);
      checkEq("R2 pulse width", lowCnt, EXP_P);
      checkEq("R4 pull-up back on", pullUpEn, 1);
      repeat (4) @(negedge clk);
      checkEq("R5 own drive not external", rstFlags[0], 0);
      checkEq("R1 sysRst released", sysRst, 0);
    end

    // R8 both software requests together
    clearAll();
    swReq = 2'b11;
    @(negedge clk);
    swReq = 2'b00;
    checkEq("R8 both software flags", rstFlags, 9'h018);
    repeat (EXP_P + 4) @(negedge clk);

    // R3 restart: second source 4 edges after the first
    clearAll();
    wwdgReq = 1'b1;
    lowCnt = 0;
    for (int k = 0; k < EXP_P + 12; k++) begin
      if (k > 0) wwdgReq = 1'b0;
      iwdgReq = (k == 4);
      @(negedge clk);
      if (pinDriveLow) lowCnt++;
    end
    checkEq("R3 restarted pulse width", lowCnt, EXP_P + 4);
    checkEq("R3 both flags", rstFlags, 9'h006);

    // R10 held brown-out wipes other flags, R1 sysRst held with it
    clearAll();
    pulseSrc(1);
    repeat (EXP_P + 4) @(negedge clk);
    borReq = 1'b1;
    @(negedge clk);
    checkEq("R10 brown-out wipes flags", rstFlags, 9'h080);
    seenRst = 1'b1;
    lowCnt = pinDriveLow ? 1 : 0;
    for (int k = 0; k < 3 * EXP_P; k++) begin
      @(negedge clk);
      if (!sysRst) seenRst = 1'b0;
      if (pinDriveLow) lowCnt++;
    end
    checkEq("R1 sysRst held with request", seenRst, 1);
    checkEq("R2 held request pulses once", lowCnt, EXP_P);
    borReq = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R1 sysRst after held request", sysRst, 0);

    // R9 set wins over a simultaneous clear, partial masks
    oblLaunch = 1'b1;
    flagClrWr = 1'b1;
    flagClrMask = 9'h1FF;
    @(negedge clk);
    oblLaunch = 1'b0;
    flagClrWr = 1'b0;
    checkEq("R9 set beats clear", rstFlags, 9'h040);
    repeat (EXP_P + 4) @(negedge clk);
    flagClrWr = 1'b1;
    flagClrMask = 9'h001;
    @(negedge clk);
    flagClrWr = 1'b0;
    checkEq("R9 unmasked flag kept", rstFlags, 9'h040);
    flagClrWr = 1'b1;
    flagClrMask = 9'h040;
    @(negedge clk);
    flagClrWr = 1'b0;
    checkEq("R9 masked flag cleared", rstFlags, 9'h000);

    // R5 filter sweep over low lengths
    for (int d = 1; d <= TB_FILT + 2; d++) begin
      clearAll();
      firstHigh = -1;
      seenDrive = 1'b0;
      for (int j = 0; j < d + 8; j++) begin
        extPull = (j < d);
        @(negedge clk);
        if (sysRst && firstHigh < 0) firstHigh = j;
        if (pinDriveLow) seenDrive = 1'b1;
      end
      checkEq("R5 external flag", rstFlags[0], (d >= TB_FILT));
      checkEq("R5 external never drives", seenDrive, 0);
      checkEq("R5 accept latency", firstHigh, (d >= TB_FILT) ? TB_FILT + 1 : -1);
    end

    // R6 / R7 low-power sweep over every mode code and option setting
    for (int m = 0; m < 4; m++) begin
      for (int o = 0; o < 8; o++) begin
        clearAll();
        expRst = (m != 0) && !o[m-1 & 3];
        expGrant = (m != 0) && !expRst;
        optLpRstN = 3'(o);
        lpMode = 2'(m);
        lpEntryDone = 1'b1;
        @(negedge clk);
        lpEntryDone = 1'b0;
        checkEq("R7 grant", lpGrant, expGrant);
        checkEq("R7 grant mode", lpGrantMode, expGrant ? m : 0);
        @(negedge clk);
        checkEq("R7 grant lasts one cycle", lpGrant, 0);
        checkEq("R6 reset instead of entry", pinDriveLow, expRst);
        repeat (EXP_P + 4) @(negedge clk);
        checkEq("R6 low-power flag", rstFlags, expRst ? 9'h020 : 9'h000);
      end
    end
    optLpRstN = 3'b111;
    lpMode = 2'b00;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule